// File: doc/BRIEF.md
# USB Endpoint Buffer CPU Access Port

This block lets a processor move packet data between its 32-bit register bus and the packet buffer of one USB endpoint. Software first picks an endpoint and a direction by writing a control register. Outbound data is sent as follows: software loads a byte count and then writes one word at a time. Each word goes straight into the buffer memory. The byte count drops by four per word, and when it reaches zero the block signals packet completion to the protocol engine. Inbound data is read the other way. The block waits until the protocol engine reports a packet for the selected endpoint, captures its length and data-valid flag, and prefetches buffer words. Software then drains the packet word by word and watches a status register that holds the remaining count and the flags.

The sequencer has six states. IDLE does nothing. TX accepts data words. RX_WAIT waits for the engine to report a packet. RX_FETCH issues a buffer read. RX_FILL captures the read word. RX_READY holds a word for software.

The transitions are:
- A control write from any state selects TX if the write-enable bit is set. Otherwise it selects RX_WAIT if the read-enable bit is set. Otherwise it selects IDLE. In every case the word pointer returns to 0.
- TX returns to IDLE on the data write that empties the count.
- RX_WAIT moves to RX_FETCH when a packet is present.
- RX_FETCH always moves to RX_FILL, and RX_FILL always moves to RX_READY.
- A data read in RX_READY goes back to RX_FETCH. If that read empties the count, it goes to IDLE instead.

Register addresses on `reg_addr`: 0 is control, 1 is the transmit byte count, 2 is data, and 3 is the receive status.

Top module: `usb_ep_cpu_port`

## Requirements
- R1: After reset the control register and the receive status both read 0, and no buffer write or completion pulse occurs.
- R2: The control register holds write-enable in bit 0, read-enable in bit 1 and the endpoint number in bits 5:2. It reads back as written, `eng_ep` follows the endpoint field, and write-enable takes precedence when both enables are set.
- R3: A data write while write-enable is set stores `reg_wdata` unchanged at buffer address {endpoint, word pointer}, with bits 7:0 carrying the first bus byte (little-endian). The pointer then advances by one word.
- R4: Each transmit data write lowers the transmit count by 4 and saturates at 0. The write that brings the count to 0 raises `tx_pkt_done` for exactly one cycle and clears write-enable, while the endpoint field is kept.
- R5: A data write while write-enable is clear causes no buffer write and no completion pulse.
- R6: Any control write returns the word pointer to word 0, so rewriting the same endpoint restarts its buffer and a new endpoint starts at its own word 0.
- R7: The transmit count register is write-only and reads as 0.
- R8: The receive status holds the remaining byte count in bits 9:0, the data-valid flag in bit 10 and packet-ready in bit 11. Bits 31:12 read 0.
- R9: With read-enable set, once `eng_rx_have` is high the engine's length and flag are captured and packet-ready is set. Data reads then return the buffer words from word 0 upward.
- R10: Each data read lowers the receive count by 4 and saturates at 0. The read that brings the count to 0 raises `rx_pkt_done` for one cycle and clears packet-ready and read-enable.
- R11: A packet whose engine flag `eng_rx_dv` is low is still delivered in full, and its status shows data-valid 0.
- R12: A data read when no word is held (any state other than RX_READY) returns 0 and leaves the receive count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| buf_addr | output | 8 | Buffer word address {endpoint, pointer} |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | 32 | Buffer write data |
| buf_re | output | 1 | Buffer read enable (data one cycle later) |
| buf_rdata | input | 32 | Buffer read data |
| eng_ep | output | 4 | Selected endpoint, to the protocol engine |
| eng_rx_have | input | 1 | Engine holds a received packet for `eng_ep` |
| eng_rx_len | input | 10 | Byte length of that packet |
| eng_rx_dv | input | 1 | Packet arrived without error |
| tx_pkt_done | output | 1 | Transmit packet complete pulse |
| rx_pkt_done | output | 1 | Receive packet drained pulse (end-of-packet event) |

## Verification
The bench targets four failure modes:
- A byte count that is not a multiple of four. A counter that wraps instead of saturating would never signal completion, and the bench would see extra writes and a missing pulse.
- A transfer aborted by a second control write. A design that keeps the old pointer would put the next word at word 1 rather than word 0.
- A data read issued while the next word is still being prefetched. A wrong design would return stale data and lose four bytes of count.
- A packet flagged invalid. Its data-valid bit must read 0 while its words still come out in order.

// File: rtl/usb_epp_pkg.sv
package usb_epp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX,
        ST_RX_WAIT,
        ST_RX_FETCH,
        ST_RX_FILL,
        ST_RX_READY
    } epp_state_t;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_TXLEN  = 2'd1;
    localparam logic [1:0] A_DATA   = 2'd2;
    localparam logic [1:0] A_RXSTAT = 2'd3;

    typedef struct packed {
        logic buf_we;
        logic buf_re;
        logic tx_dec;
        logic rx_dec;
        logic rx_load;
        logic ptr_clr;
        logic ptr_inc;
        logic hold_ld;
        logic tx_done;
        logic rx_done;
        logic en_clr;
    } epp_ctl_t;

endpackage

// File: rtl/usb_epp_bytecnt.sv
module usb_epp_bytecnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         last
);
    localparam logic [W-1:0] STEP = W'(4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= (cnt > STEP) ? cnt - STEP : '0;
    end

    assign last = (cnt <= STEP);
endmodule

// File: rtl/usb_epp_fsm.sv
module usb_epp_fsm
    import usb_epp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       new_wr_en,
    input  logic       new_rd_en,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic       tx_last,
    input  logic       rx_last,
    input  logic       eng_rx_have,
    output epp_state_t state,
    output epp_ctl_t   ctl
);
    epp_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        if (ctrl_wr) begin
            if (new_wr_en)      state_d = ST_TX;
            else if (new_rd_en) state_d = ST_RX_WAIT;
            else                state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_d = ST_IDLE;
                ST_TX:       if (data_wr && tx_last) state_d = ST_IDLE;
                ST_RX_WAIT:  if (eng_rx_have) state_d = ST_RX_FETCH;
                ST_RX_FETCH: state_d = ST_RX_FILL;
                ST_RX_FILL:  state_d = ST_RX_READY;
                ST_RX_READY: if (data_rd) state_d = rx_last ? ST_IDLE : ST_RX_FETCH;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl = '0;
        if (ctrl_wr) begin
            ctl.ptr_clr = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_TX: if (data_wr) begin
                    ctl.buf_we  = 1'b1;
                    ctl.ptr_inc = 1'b1;
                    ctl.tx_dec  = 1'b1;
                    ctl.tx_done = tx_last;
                    ctl.en_clr  = tx_last;
                end
                ST_RX_WAIT:  ctl.rx_load = eng_rx_have;
                ST_RX_FETCH: ctl.buf_re  = 1'b1;
                ST_RX_FILL:  ctl.hold_ld = 1'b1;
                ST_RX_READY: if (data_rd) begin
                    ctl.rx_dec  = 1'b1;
                    ctl.ptr_inc = 1'b1;
                    ctl.rx_done = rx_last;
                    ctl.en_clr  = rx_last;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/usb_ep_cpu_port.sv
module usb_ep_cpu_port
    import usb_epp_pkg::*;
#(
    parameter int EP_W          = 4,
    parameter int LEN_W         = 10,
    parameter int MAX_PKT_BYTES = 64,
    localparam int WORDS        = MAX_PKT_BYTES / 4,
    localparam int PTR_W        = $clog2(WORDS),
    localparam int AW           = EP_W + PTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic [AW-1:0]    buf_addr,
    output logic             buf_we,
    output logic [31:0]      buf_wdata,
    output logic             buf_re,
    input  logic [31:0]      buf_rdata,
    output logic [EP_W-1:0]  eng_ep,
    input  logic             eng_rx_have,
    input  logic [LEN_W-1:0] eng_rx_len,
    input  logic             eng_rx_dv,
    output logic             tx_pkt_done,
    output logic             rx_pkt_done
);
    logic             ctrl_wr, txlen_wr, data_wr, data_rd;
    logic             wr_en_q, rd_en_q, rx_dv_q, pkt_rdy;
    logic [EP_W-1:0]  ep_q;
    logic [PTR_W-1:0] ptr_q;
    logic [31:0]      hold_q;
    logic [LEN_W-1:0] tx_cnt, rx_cnt;
    logic             tx_last, rx_last;
    epp_state_t       state;
    epp_ctl_t         ctl;

    assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
    assign txlen_wr = reg_wr && (reg_addr == A_TXLEN);
    assign data_wr  = reg_wr && (reg_addr == A_DATA);
    assign data_rd  = reg_rd && (reg_addr == A_DATA);

    usb_epp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .new_wr_en   (reg_wdata[0]),
        .new_rd_en   (reg_wdata[1]),
        .data_wr     (data_wr),
        .data_rd     (data_rd),
        .tx_last     (tx_last),
        .rx_last     (rx_last),
        .eng_rx_have (eng_rx_have),
        .state       (state),
        .ctl         (ctl)
    );

    usb_epp_bytecnt #(.W(LEN_W)) u_tx_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (txlen_wr),
        .load_val (reg_wdata[LEN_W-1:0]),
        .dec      (ctl.tx_dec),
        .cnt      (tx_cnt),
        .last     (tx_last)
    );

    usb_epp_bytecnt #(.W(LEN_W)) u_rx_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctl.rx_load),
        .load_val (eng_rx_len),
        .dec      (ctl.rx_dec),
        .cnt      (rx_cnt),
        .last     (rx_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en_q <= 1'b0;
            rd_en_q <= 1'b0;
            ep_q    <= '0;
        end else if (ctrl_wr) begin
            wr_en_q <= reg_wdata[0];
            rd_en_q <= reg_wdata[1];
            ep_q    <= reg_wdata[2 +: EP_W];
        end else if (ctl.en_clr) begin
            wr_en_q <= 1'b0;
            rd_en_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           ptr_q <= '0;
        else if (ctl.ptr_clr) ptr_q <= '0;
        else if (ctl.ptr_inc) ptr_q <= ptr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            rx_dv_q <= 1'b0;
        end else begin
            if (ctl.hold_ld) hold_q  <= buf_rdata;
            if (ctl.rx_load) rx_dv_q <= eng_rx_dv;
        end
    end

    assign pkt_rdy = (state == ST_RX_FETCH) || (state == ST_RX_FILL) ||
                     (state == ST_RX_READY);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:   reg_rdata[2 + EP_W - 1:0] = {ep_q, rd_en_q, wr_en_q};
            A_TXLEN:  reg_rdata = '0;
            A_DATA:   reg_rdata = (state == ST_RX_READY) ? hold_q : '0;
            A_RXSTAT: reg_rdata[LEN_W + 1:0] = {pkt_rdy, rx_dv_q, rx_cnt};
            default:  reg_rdata = '0;
        endcase
    end

    assign buf_addr    = {ep_q, ptr_q};
    assign buf_we      = ctl.buf_we;
    assign buf_re      = ctl.buf_re;
    assign buf_wdata   = reg_wdata;
    assign eng_ep      = ep_q;
    assign tx_pkt_done = ctl.tx_done;
    assign rx_pkt_done = ctl.rx_done;
endmodule

// File: rtl/usb_ep_cpu_port_chk.sv
module usb_ep_cpu_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_rdata,
    input logic        buf_we,
    input logic        buf_re,
    input logic        tx_pkt_done,
    input logic        rx_pkt_done,
    input logic        wr_en_q,
    input logic        rd_en_q,
    input logic        pkt_rdy,
    input logic        ctrl_wr
);
    // R4: completion is a single-cycle pulse
    p_tx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pkt_done |=> !tx_pkt_done);

    // R4: completion drops write-enable
    p_tx_clears_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pkt_done && !ctrl_wr |=> !wr_en_q);

    // R5: no buffer write unless write-enable was set
    p_we_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> wr_en_q);

    // R9: buffer fetch only while a packet is being read
    p_re_needs_rden_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_re |-> (rd_en_q && pkt_rdy && !buf_we));

    // R10: draining clears packet-ready and read-enable
    p_rx_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pkt_done |=> (!pkt_rdy && !rd_en_q));

    // R8: reserved status bits are zero
    p_stat_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd3) |-> (reg_rdata[31:12] == 20'd0));
endmodule

bind usb_ep_cpu_port usb_ep_cpu_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .buf_we      (buf_we),
    .buf_re      (buf_re),
    .tx_pkt_done (tx_pkt_done),
    .rx_pkt_done (rx_pkt_done),
    .wr_en_q     (wr_en_q),
    .rd_en_q     (rd_en_q),
    .pkt_rdy     (pkt_rdy),
    .ctrl_wr     (ctrl_wr)
);

// File: tb/usb_ep_cpu_port_bench.sv
module usb_ep_cpu_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  buf_addr;
    logic        buf_we, buf_re;
    logic [31:0] buf_wdata;
    logic [31:0] buf_rdata = '0;
    logic [3:0]  eng_ep;
    logic        eng_rx_have = 1'b0;
    logic [9:0]  eng_rx_len = '0;
    logic        eng_rx_dv = 1'b0;
    logic        tx_pkt_done, rx_pkt_done;

    int nchk = 0, nfail = 0;
    int tx_pulses = 0, rx_pulses = 0;
    int exp_tx = 0, exp_rx = 0;
    logic [39:0] exp_wr[$];
    logic [31:0] mem [256];

    // behavioural model state
    int m_ep = 0, m_ptr = 0, m_left = 0, m_rx_left = 0;
    bit m_wren = 0;

    always #2 clk = ~clk;

    usb_ep_cpu_port u_usb_ep_cpu_port (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // buffer memory model and per-clock write comparison
    always @(posedge clk) begin
        if (rst_n) begin
            if (tx_pkt_done) tx_pulses++;
            if (rx_pkt_done) rx_pulses++;
            if (buf_we) begin
                if (exp_wr.size() == 0) begin
                    chk("R5 unexpected buffer write", {24'd0, buf_addr}, 32'hFFFF_FFFF);
                end else begin
                    logic [39:0] e;
                    e = exp_wr.pop_front();
                    chk("R3 write address", {24'd0, buf_addr}, {24'd0, e[39:32]});
                    chk("R3 write data", buf_wdata, e[31:0]);
                end
                mem[buf_addr] <= buf_wdata;
            end
            if (buf_re) buf_rdata <= mem[buf_addr];
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ctrl(input int ep, input bit we, input bit re);
        m_ep = ep; m_ptr = 0; m_wren = we;
        wr(2'd0, {26'd0, ep[3:0], re, we});
    endtask

    task automatic txlen(input int n);
        m_left = n;
        wr(2'd1, 32'(n));
    endtask

    task automatic txword(input logic [31:0] d);
        if (m_wren) begin
            exp_wr.push_back({m_ep[3:0], m_ptr[3:0], d});
            m_ptr++;
            m_left = (m_left > 4) ? m_left - 4 : 0;
            if (m_left == 0) begin m_wren = 0; exp_tx++; end
        end
        wr(2'd2, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(2'd0, v); chk("R1 control after reset", v, 32'd0);
        rd(2'd3, v); chk("R1 status after reset", v, 32'd0);
        chk("R1 no pulse after reset", 32'(tx_pulses + rx_pulses), 32'd0);

        // R2/R3/R4: 10-byte packet to endpoint 6, last word partial
        ctrl(6, 1, 0);
        rd(2'd0, v); chk("R2 control readback", v, 32'h19);
        chk("R2 endpoint to engine", {28'd0, eng_ep}, 32'd6);
        txlen(10);
        txword(32'h4433_2211);
        txword(32'h8877_6655);
        chk("R4 no early completion", 32'(tx_pulses), 32'(exp_tx));
        txword(32'h0000_AA99);
        chk("R4 completion after saturating count", 32'(tx_pulses), 32'(exp_tx));
        rd(2'd0, v); chk("R4 write-enable cleared, endpoint kept", v, 32'h18);

        // R5: data write with write-enable clear
        txword(32'hDEAD_BEEF);
        idle(2);
        chk("R5 ignored write no pulse", 32'(tx_pulses), 32'(exp_tx));
        chk("R5 ignored write no buffer access", 32'(exp_wr.size()), 32'd0);

        // R6: abort and restart endpoint 5
        ctrl(5, 1, 0);
        txlen(12);
        txword(32'h1111_0000);
        ctrl(5, 1, 0);
        txlen(8);
        txword(32'h5555_0000);
        txword(32'h5555_0001);
        chk("R6 restart completes", 32'(tx_pulses), 32'(exp_tx));

        // R6: new endpoint starts at word 0; R2 precedence of write-enable
        ctrl(2, 1, 0);
        m_wren = 1;
        wr(2'd0, {26'd0, 4'd2, 1'b1, 1'b1});
        txlen(4);
        txword(32'hCAFE_0002);
        chk("R2 write-enable wins, single-word packet", 32'(tx_pulses), 32'(exp_tx));

        // R7
        rd(2'd1, v); chk("R7 transmit count reads zero", v, 32'd0);

        // R12: data read while idle
        rd(2'd2, v); chk("R12 idle data read", v, 32'd0);

        // R8/R9/R10: receive 10 bytes from endpoint 6
        eng_rx_have = 1'b1; eng_rx_len = 10'd10; eng_rx_dv = 1'b1;
        ctrl(6, 0, 1);
        m_rx_left = 10;
        idle(5);
        rd(2'd3, v); chk("R8 status on packet ready", v, 32'hC0A);
        rd(2'd2, v); chk("R9 first word", v, 32'h4433_2211);
        rd(2'd2, v); chk("R12 read during prefetch", v, 32'd0);
        rd(2'd3, v); chk("R10 count after one read", v, 32'hC06);
        idle(2);
        rd(2'd2, v); chk("R9 second word", v, 32'h8877_6655);
        idle(3);
        rd(2'd3, v); chk("R10 count after two reads", v, 32'hC02);
        exp_rx++;
        rd(2'd2, v); chk("R9 third word", v, 32'h0000_AA99);
        chk("R10 drain pulse", 32'(rx_pulses), 32'(exp_rx));
        rd(2'd3, v); chk("R10 status after drain", v, 32'h400);
        rd(2'd0, v); chk("R10 read-enable cleared", v, 32'h18);

        // R11: packet flagged in error still delivered
        eng_rx_len = 10'd4; eng_rx_dv = 1'b0;
        ctrl(2, 0, 1);
        idle(5);
        rd(2'd3, v); chk("R11 status with data-valid low", v, 32'h804);
        exp_rx++;
        rd(2'd2, v); chk("R11 word delivered", v, 32'hCAFE_0002);
        chk("R11 drain pulse", 32'(rx_pulses), 32'(exp_rx));
        rd(2'd3, v); chk("R11 status after drain", v, 32'h000);
        eng_rx_have = 1'b0;

        idle(2);
        chk("R4 total transmit pulses", 32'(tx_pulses), 32'(exp_tx));
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #800000;
        nchk++; nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule